// File: doc/BRIEF.md
# Predicated Writeback Condition Unit

This block sits at the writeback end of a simple in-order datapath. Every instruction that reaches it carries a four-bit predicate code. The unit tests that code against a flag register it keeps itself, which holds negative, zero, carry and overflow. The test result decides whether the instruction's register write happens. An instruction whose predicate fails still uses its slot, but its write enable stays low and the destination keeps its old value.

The unit handles three kinds of instruction:

- **Plain write.** The unit passes operand A through as the write data, but only when the predicate holds.
- **Conditional select.** The instruction always writes. The predicate chooses whether the data is operand A or operand B.
- **Compare.** The unit computes A minus B and loads the four flags from the result. It never asserts a register write. The new flags are registered, so the next instruction is the first to see them.

A compare whose own predicate fails leaves the flags untouched.

Top module: `pwc_unit`

## Requirements
- R1: While reset is high the flag register clears to N=0, Z=0, C=0, V=0, and `flags_o` shows 4'b0000 on the first cycle after reset falls. The bit order of `flags_o` is {N,Z,C,V}, with N in bit 3.
- R2: `cond_i` selects the predicate as follows, where `!` is negation:
  - 0 = Z, 1 = !Z
  - 2 = C, 3 = !C
  - 4 = N, 5 = !N
  - 6 = V, 7 = !V
  - 8 = C&!Z, 9 = !C|Z
  - 10 = N==V, 11 = N!=V
  - 12 = !Z&(N==V), 13 = Z|(N!=V)
  - 14 = always true, 15 = never true
- R3: A plain write (`wr_req_i`=1, `csel_i`=0, `cmp_i`=0, `valid_i`=1) whose predicate is false drives `wr_en_o` low.
- R4: A plain write whose predicate is true drives `wr_en_o` high in the same cycle, and `wr_data_o` equals `a_i`.
- R5: A conditional select (`csel_i`=1, `wr_req_i`=1, `valid_i`=1) always drives `wr_en_o` high. `wr_data_o` is `a_i` when the predicate is true and `b_i` when it is false.
- R6: A compare (`cmp_i`=1, `valid_i`=1) whose predicate is true never drives `wr_en_o`. On the following cycle `flags_o` holds the flags of the W-bit difference r = a - b:
  - N is the top bit of r.
  - Z is set when r is zero.
  - C is set when a >= b unsigned, i.e. no borrow.
  - V is set on signed overflow.
- R7: A compare whose predicate is false leaves `flags_o` unchanged.
- R8: With `valid_i` low, `wr_en_o` stays low and the flags do not change, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction occupies this slot |
| cond_i | input | 4 | Predicate code of the instruction |
| cmp_i | input | 1 | Compare: update flags from a_i - b_i |
| wr_req_i | input | 1 | Instruction requests a register write |
| csel_i | input | 1 | Conditional select instead of plain write |
| a_i | input | DATA_W | First source operand |
| b_i | input | DATA_W | Second source operand |
| wr_en_o | output | 1 | Gated register-file write enable |
| wr_data_o | output | DATA_W | Data for the register-file write |
| flags_o | output | 4 | Current flags {N,Z,C,V} |

## Verification
`wr_en_o` and `wr_data_o` are combinational, so each is due in the same cycle as the instruction that produces it. The bench drives inputs on the falling edge and samples these two outputs one nanosecond later. Flags from a compare appear only after the next rising edge. The bench therefore reads `flags_o` at the falling edge that follows. In that same slot it confirms that a failing or invalid compare left the value it observed earlier unchanged.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } pwc_flags_t;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } pwc_cond_e;

    localparam pwc_flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    function automatic logic pwc_test(input pwc_cond_e cc, input pwc_flags_t f);
        logic r;
        case (cc)
            CC_EQ:   r = f.z;
            CC_NE:   r = !f.z;
            CC_CS:   r = f.c;
            CC_CC:   r = !f.c;
            CC_MI:   r = f.n;
            CC_PL:   r = !f.n;
            CC_VS:   r = f.v;
            CC_VC:   r = !f.v;
            CC_HI:   r = f.c && !f.z;
            CC_LS:   r = !f.c || f.z;
            CC_GE:   r = (f.n == f.v);
            CC_LT:   r = (f.n != f.v);
            CC_GT:   r = !f.z && (f.n == f.v);
            CC_LE:   r = f.z || (f.n != f.v);
            CC_AL:   r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwc_cond_eval.sv
module pwc_cond_eval
    import pwc_pkg::*;
(
    input  logic [3:0] cond_i,
    input  pwc_flags_t flags_i,
    output logic       pass_o
);
    always_comb begin
        pass_o = pwc_test(pwc_cond_e'(cond_i), flags_i);
    end
endmodule

// File: rtl/pwc_flag_reg.sv
module pwc_flag_reg
    import pwc_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output pwc_flags_t        flags_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]   diff_ext;
    logic [DATA_W-1:0] diff;
    pwc_flags_t        nxt;
    pwc_flags_t        cur;

    always_comb begin
        diff_ext = {1'b0, a_i} - {1'b0, b_i};
        diff     = diff_ext[DATA_W-1:0];
        nxt.n    = diff[MSB];
        nxt.z    = (diff == '0);
        nxt.c    = !diff_ext[DATA_W];
        nxt.v    = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);
    end

    always_ff @(posedge clk) begin
        if (rst)        cur <= FLAGS_RESET;
        else if (upd_i) cur <= nxt;
    end

    assign flags_o = cur;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(flags_o)); // R7
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flags_o == FLAGS_RESET)); // R1
    AST_ZERO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (upd_i && a_i == b_i) |=> (flags_o.z && flags_o.c && !flags_o.v)); // R6
endmodule

// File: rtl/pwc_wb_gate.sv
module pwc_wb_gate #(
    parameter int DATA_W = 32
)(
    input  logic              valid_i,
    input  logic              pass_i,
    input  logic              wr_req_i,
    input  logic              csel_i,
    input  logic              cmp_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o
);
    logic live;

    always_comb begin
        live      = valid_i && wr_req_i && !cmp_i;
        wr_en_o   = live && (csel_i || pass_i);
        wr_data_o = (csel_i && !pass_i) ? b_i : a_i;
    end

    always_comb begin
        if (!valid_i) AST_IDLE_NO_WRITE: assert (!wr_en_o); // R8
    end
endmodule

// File: rtl/pwc_unit.sv
module pwc_unit
    import pwc_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [3:0]        cond_i,
    input  logic              cmp_i,
    input  logic              wr_req_i,
    input  logic              csel_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [3:0]        flags_o
);
    pwc_flags_t flags;
    logic       pass;
    logic       flag_upd;

    pwc_cond_eval u_eval (
        .cond_i  (cond_i),
        .flags_i (flags),
        .pass_o  (pass)
    );

    assign flag_upd = valid_i && cmp_i && pass;

    pwc_flag_reg #(.DATA_W(DATA_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .upd_i   (flag_upd),
        .a_i     (a_i),
        .b_i     (b_i),
        .flags_o (flags)
    );

    pwc_wb_gate #(.DATA_W(DATA_W)) u_gate (
        .valid_i   (valid_i),
        .pass_i    (pass),
        .wr_req_i  (wr_req_i),
        .csel_i    (csel_i),
        .cmp_i     (cmp_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .wr_en_o   (wr_en_o),
        .wr_data_o (wr_data_o)
    );

    assign flags_o = flags;

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cmp_i) |-> !wr_en_o); // R6
    AST_NEVER_CODE: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cond_i == 4'd15 && !csel_i) |-> !wr_en_o); // R2
    AST_PLAIN_DATA: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && !csel_i) |-> (wr_data_o == a_i)); // R4
    AST_CSEL_ALWAYS: assert property (@(posedge clk) disable iff (rst)
        (valid_i && csel_i && wr_req_i && !cmp_i) |-> (wr_en_o && (wr_data_o == a_i || wr_data_o == b_i))); // R5
    AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(flags_o)); // R8
endmodule

// File: tb/sim_pwc_unit.sv
`timescale 1ns/1ps
module sim_pwc_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_i = 1'b0;
    logic [3:0]   cond_i = 4'd14;
    logic         cmp_i = 1'b0;
    logic         wr_req_i = 1'b0;
    logic         csel_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         wr_en_o;
    logic [W-1:0] wr_data_o;
    logic [3:0]   flags_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] mflags;

    always #2.5 clk = ~clk;

    pwc_unit #(.DATA_W(W)) u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .cond_i(cond_i), .cmp_i(cmp_i),
        .wr_req_i(wr_req_i), .csel_i(csel_i), .a_i(a_i), .b_i(b_i),
        .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .flags_o(flags_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit model_cond(input logic [3:0] cc, input logic [3:0] f);
        bit n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c & !z;
            4'd9:  return !c | z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z & (n == v);
            4'd13: return z | (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] model_cmp(input int a, input int b);
        int diff, sa, sb, sd;
        bit n, z, c, v;
        diff = (a - b) & 255;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        sd = sa - sb;
        n = diff >= 128;
        z = diff == 0;
        c = a >= b;
        v = (sd > 127) || (sd < -128);
        return {n, z, c, v};
    endfunction

    task automatic idle();
        valid_i = 1'b0; cmp_i = 1'b0; wr_req_i = 1'b0; csel_i = 1'b0;
    endtask

    task automatic do_cmp(input int a, input int b, input logic [3:0] cc, input bit vld);
        bit taken;
        @(negedge clk);
        taken = vld && model_cond(cc, mflags);
        valid_i = vld; cmp_i = 1'b1; wr_req_i = 1'b1; csel_i = 1'b0;
        cond_i = cc; a_i = a[W-1:0]; b_i = b[W-1:0];
        #1;
        if (vld) chk(wr_en_o == 1'b0, "R6 compare write", int'(wr_en_o), 0);
        else     chk(wr_en_o == 1'b0, "R8 invalid write", int'(wr_en_o), 0);
        @(negedge clk);
        idle();
        if (taken) mflags = model_cmp(a, b);
        if (taken)    chk(flags_o == mflags, "R6 flags", int'(flags_o), int'(mflags));
        else if (vld) chk(flags_o == mflags, "R7 flags held", int'(flags_o), int'(mflags));
        else          chk(flags_o == mflags, "R8 flags held", int'(flags_o), int'(mflags));
    endtask

    task automatic sweep_conds(input int a, input int b);
        for (int cc = 0; cc < 16; cc++) begin
            bit exp;
            exp = model_cond(cc[3:0], mflags);
            valid_i = 1'b1; cmp_i = 1'b0; wr_req_i = 1'b1; csel_i = 1'b0;
            cond_i = cc[3:0]; a_i = a[W-1:0]; b_i = b[W-1:0];
            #0.2;
            if (exp) begin
                chk(wr_en_o == 1'b1, "R4 R2 enable", int'(wr_en_o), 1);
                chk(wr_data_o == a_i, "R4 data", int'(wr_data_o), int'(a_i));
            end else begin
                chk(wr_en_o == 1'b0, "R3 R2 enable", int'(wr_en_o), 0);
            end
            csel_i = 1'b1;
            #0.2;
            chk(wr_en_o == 1'b1, "R5 enable", int'(wr_en_o), 1);
            chk(wr_data_o == (exp ? a_i : b_i), "R5 data", int'(wr_data_o), int'(exp ? a_i : b_i));
            valid_i = 1'b0;
            #0.1;
            chk(wr_en_o == 1'b0, "R8 idle enable", int'(wr_en_o), 0);
        end
        idle();
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        mflags = 4'b0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(flags_o == 4'b0000, "R1 reset flags", int'(flags_o), 0);
        chk(wr_en_o == 1'b0, "R8 reset idle", int'(wr_en_o), 0);
        for (int ia = 0; ia < 256; ia += 17) begin
            for (int ib = 0; ib < 256; ib += 17) begin
                int a, b;
                a = (ia == 136) ? 128 : ia;
                b = (ib == 119) ? 127 : ib;
                do_cmp(a, b, 4'd14, 1'b1);
                @(negedge clk);
                sweep_conds(a ^ 8'h5A, b ^ 8'hA5);
                do_cmp(b, a, 4'd15, 1'b1);
                do_cmp(b, a, 4'd14, 1'b0);
                do_cmp(b ^ 1, a, mflags[2] ? 4'd1 : 4'd0, 1'b1);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule